// File: doc/BRIEF.md
# Byte-Stepped I2C Master Engine

This block is an I2C bus master that software drives one bus step at a time. Each step is a start, a repeated start, a stop, an address byte or a data byte. Software writes an 8-bit control register to choose and launch the step. The engine then runs the bit-level waveform on open-drain SCL and SDA. When the step is over, it raises a step-done flag and loads an 8-bit status code that says what happened on the bus. Software reads the code and launches the next step.

Addresses are 7-bit. Software places the address, shifted up one place with the direction bit in bit 0, in the data register and sends it as an ordinary byte. After an acknowledged read address, the bytes that follow are received. The control register's acknowledge bit then chooses whether the master answers each received byte with ACK or NACK.

SCL and SDA are modelled as active-low drive enables. The bus pulls each line high when it is not driven. Every bit spends four quarter phases of `QUARTER_CYCLES` clock cycles each. SCL is high during the middle two quarters. SDA is sampled at the end of the first high quarter.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset the status is 0xF8, the control readback is 0x00, the flag is clear and neither SCL nor SDA is driven.
- R2: Control bit positions are enable 0x40, start request 0x20, stop request 0x10, step-done flag 0x08 and acknowledge 0x04. A start or stop request reads back as 1 until its step ends, and the flag bit mirrors `irq`.
- R3: A start launched with the bus free makes SDA fall while SCL is high, then sets the flag with status 0x08.
- R4: A start launched while the bus is already held makes a repeated start on the wire and reports status 0x10.
- R5: The byte after a start is the address byte. It goes out MSB first from the data register, and SDA is released for the ninth bit. The status is 0x18 (bit 0 = 0, ACK), 0x20 (bit 0 = 0, NACK), 0x40 (bit 0 = 1, ACK) or 0x48 (bit 0 = 1, NACK).
- R6: A data byte sent after a write address reports 0x28 when acknowledged and 0x30 when not.
- R7: After an acknowledged read address, a launched byte is received MSB first into the data register. With the acknowledge bit set the master drives SDA low on the ninth bit and reports 0x50. With it clear the master leaves SDA released and reports 0x58.
- R8: While the flag is set on a held bus, SCL is driven low. A control write with enable set clears the flag and starts the next step.
- R9: A stop makes SDA rise while SCL is high, sets status 0xF8, leaves the flag clear and releases both lines.
- R10: Launching a byte (enable alone) while the bus is not held sets the flag with status 0x00 and produces no SCL activity.
- R11: A control write with enable clear has no effect. Control and data writes made while a step is running are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctlWrEn | input | 1 | Write strobe for the control register |
| dataWrEn | input | 1 | Write strobe for the data register |
| wrData | input | 8 | Write value for either register |
| ctlOut | output | 8 | Control readback, including the flag |
| dataOut | output | 8 | Data register: byte to send or byte received |
| statusOut | output | 8 | Status code of the last finished step |
| irq | output | 1 | Step-done flag |
| sclDrvLow | output | 1 | Drive SCL low when 1 |
| sdaDrvLow | output | 1 | Drive SDA low when 1 |
| sdaIn | input | 1 | Resolved SDA line level |

## Verification
The bench builds the block with `QUARTER_CYCLES` set to 4, so a full byte with its acknowledge bit takes 144 clocks. At that length a single run covers a whole write transaction and a whole read transaction, both address-NACK codes, the error path and the ignored-write cases. A small bus model in the bench resolves the open-drain lines and acts as the addressed device: it acknowledges or refuses bytes and sends data. It also watches the wire for start and stop conditions and records the bits clocked on each SCL rise.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

  localparam int BYTE_BITS = 8;

  // control register bit positions
  localparam int CTL_EN  = 6;
  localparam int CTL_STA = 5;
  localparam int CTL_STO = 4;
  localparam int CTL_FLG = 3;
  localparam int CTL_AAK = 2;

  // status codes
  localparam logic [7:0] ST_ERR     = 8'h00;
  localparam logic [7:0] ST_START   = 8'h08;
  localparam logic [7:0] ST_RESTART = 8'h10;
  localparam logic [7:0] ST_AW_ACK  = 8'h18;
  localparam logic [7:0] ST_AW_NAK  = 8'h20;
  localparam logic [7:0] ST_TX_ACK  = 8'h28;
  localparam logic [7:0] ST_TX_NAK  = 8'h30;
  localparam logic [7:0] ST_AR_ACK  = 8'h40;
  localparam logic [7:0] ST_AR_NAK  = 8'h48;
  localparam logic [7:0] ST_RX_ACK  = 8'h50;
  localparam logic [7:0] ST_RX_NAK  = 8'h58;
  localparam logic [7:0] ST_IDLE    = 8'hF8;

  typedef enum logic [1:0] {PH_IDLE, PH_START, PH_STOP, PH_BYTE} phase_e;

  typedef struct packed {
    logic tmrRun;
    logic loadShift;
    logic capBit;
    logic shiftBit;
    logic capRx;
    logic hostWr;
  } dp_strobe_t;

endpackage

// File: rtl/i2cb_datapath.sv
module i2cb_datapath
  import i2cb_pkg::*;
#(
  parameter int QUARTER_CYCLES = 25
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dp_strobe_t           strb,
  input  logic [BYTE_BITS-1:0] wrData,
  input  logic                 sdaIn,
  output logic                 qTick,
  output logic                 txBit,
  output logic                 rxBit,
  output logic [BYTE_BITS-1:0] dataReg
);

  localparam int CNT_W = (QUARTER_CYCLES > 1) ? $clog2(QUARTER_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(QUARTER_CYCLES - 1);

  logic [CNT_W-1:0]     quarterCnt;
  logic [BYTE_BITS-1:0] shiftReg;
  logic                 bitLatch;

  assign qTick = strb.tmrRun && (quarterCnt == CNT_LAST);
  assign txBit = shiftReg[BYTE_BITS-1];
  assign rxBit = bitLatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quarterCnt <= '0;
    end else if (!strb.tmrRun || quarterCnt == CNT_LAST) begin
      quarterCnt <= '0;
    end else begin
      quarterCnt <= quarterCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitLatch <= 1'b1;
      dataReg  <= '0;
    end else begin
      if (strb.capBit) bitLatch <= sdaIn;
      if (strb.loadShift) begin
        shiftReg <= dataReg;
      end else if (strb.shiftBit) begin
        shiftReg <= {shiftReg[BYTE_BITS-2:0], bitLatch};
      end
      if (strb.hostWr) begin
        dataReg <= wrData;
      end else if (strb.capRx) begin
        dataReg <= shiftReg;
      end
    end
  end

endmodule

// File: rtl/i2cb_control.sv
module i2cb_control
  import i2cb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ctlWrEn,
  input  logic                 dataWrEn,
  input  logic [BYTE_BITS-1:0] wrData,
  input  logic                 qTick,
  input  logic                 txBit,
  input  logic                 rxBit,
  input  logic                 addrRw,
  output dp_strobe_t           strb,
  output logic [7:0]           ctlOut,
  output logic [7:0]           statusOut,
  output logic                 flag,
  output logic                 sclDrvLow,
  output logic                 sdaDrvLow
);

  localparam int BIT_CNT_W = $clog2(BYTE_BITS + 1);
  localparam logic [BIT_CNT_W-1:0] ACK_SLOT = BIT_CNT_W'(BYTE_BITS);

  phase_e               phase;
  logic [1:0]           quarter;
  logic [BIT_CNT_W-1:0] bitCnt;
  logic busHeld, expectAddr, rdDir, enBit, aakBit, staPend, stoPend;
  logic [7:0] status;

  logic isIdle, accept, lastQ, rxMode, inByte, ackSlot;

  assign isIdle  = (phase == PH_IDLE);
  assign accept  = ctlWrEn && isIdle && wrData[CTL_EN];
  assign lastQ   = qTick && (quarter == 2'd3);
  assign rxMode  = rdDir && !expectAddr;
  assign inByte  = (phase == PH_BYTE);
  assign ackSlot = (bitCnt == ACK_SLOT);

  always_comb begin
    strb.tmrRun    = !isIdle;
    strb.loadShift = accept && !wrData[CTL_STA] && !wrData[CTL_STO] && busHeld;
    strb.capBit    = inByte && qTick && (quarter == 2'd1);
    strb.shiftBit  = inByte && lastQ && !ackSlot;
    strb.capRx     = inByte && lastQ && ackSlot && rxMode;
    strb.hostWr    = dataWrEn && isIdle;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= PH_IDLE;
      quarter    <= '0;
      bitCnt     <= '0;
      busHeld    <= 1'b0;
      expectAddr <= 1'b0;
      rdDir      <= 1'b0;
      enBit      <= 1'b0;
      aakBit     <= 1'b0;
      staPend    <= 1'b0;
      stoPend    <= 1'b0;
      flag       <= 1'b0;
      status     <= ST_IDLE;
    end else if (accept) begin
      enBit   <= 1'b1;
      aakBit  <= wrData[CTL_AAK];
      flag    <= 1'b0;
      quarter <= '0;
      bitCnt  <= '0;
      if (wrData[CTL_STA]) begin
        staPend <= 1'b1;
        phase   <= PH_START;
      end else if (wrData[CTL_STO]) begin
        if (busHeld) begin
          stoPend <= 1'b1;
          phase   <= PH_STOP;
        end else begin
          status <= ST_IDLE;
        end
      end else if (busHeld) begin
        phase <= PH_BYTE;
      end else begin
        status <= ST_ERR;
        flag   <= 1'b1;
      end
    end else if (qTick) begin
      quarter <= quarter + 2'd1;
      if (quarter == 2'd3) begin
        unique case (phase)
          PH_START: begin
            status     <= busHeld ? ST_RESTART : ST_START;
            busHeld    <= 1'b1;
            expectAddr <= 1'b1;
            rdDir      <= 1'b0;
            staPend    <= 1'b0;
            flag       <= 1'b1;
            phase      <= PH_IDLE;
          end
          PH_STOP: begin
            status     <= ST_IDLE;
            busHeld    <= 1'b0;
            expectAddr <= 1'b0;
            rdDir      <= 1'b0;
            stoPend    <= 1'b0;
            phase      <= PH_IDLE;
          end
          PH_BYTE: begin
            if (ackSlot) begin
              phase <= PH_IDLE;
              flag  <= 1'b1;
              if (expectAddr) begin
                expectAddr <= 1'b0;
                rdDir      <= addrRw && !rxBit;
                if (addrRw) status <= rxBit ? ST_AR_NAK : ST_AR_ACK;
                else        status <= rxBit ? ST_AW_NAK : ST_AW_ACK;
              end else if (rdDir) begin
                status <= aakBit ? ST_RX_ACK : ST_RX_NAK;
              end else begin
                status <= rxBit ? ST_TX_NAK : ST_TX_ACK;
              end
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

  // line drive per phase and quarter
  always_comb begin
    unique case (phase)
      PH_START: begin
        sclDrvLow = (quarter == 2'd0) ? busHeld : (quarter == 2'd3);
        sdaDrvLow = quarter[1];
      end
      PH_STOP: begin
        sclDrvLow = (quarter == 2'd0);
        sdaDrvLow = (quarter != 2'd3);
      end
      PH_BYTE: begin
        sclDrvLow = (quarter == 2'd0) || (quarter == 2'd3);
        sdaDrvLow = ackSlot ? (rxMode && aakBit) : (!rxMode && !txBit);
      end
      default: begin
        sclDrvLow = busHeld;
        sdaDrvLow = 1'b0;
      end
    endcase
  end

  assign statusOut = status;
  assign ctlOut    = {1'b0, enBit, staPend, stoPend, flag, aakBit, 2'b00};

endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cb_pkg::*;
#(
  parameter int QUARTER_CYCLES = 25
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctlWrEn,
  input  logic       dataWrEn,
  input  logic [7:0] wrData,
  output logic [7:0] ctlOut,
  output logic [7:0] dataOut,
  output logic [7:0] statusOut,
  output logic       irq,
  output logic       sclDrvLow,
  output logic       sdaDrvLow,
  input  logic       sdaIn
);

  dp_strobe_t strb;
  logic qTick, txBit, rxBit;

  i2cb_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ctlWrEn   (ctlWrEn),
    .dataWrEn  (dataWrEn),
    .wrData    (wrData),
    .qTick     (qTick),
    .txBit     (txBit),
    .rxBit     (rxBit),
    .addrRw    (dataOut[0]),
    .strb      (strb),
    .ctlOut    (ctlOut),
    .statusOut (statusOut),
    .flag      (irq),
    .sclDrvLow (sclDrvLow),
    .sdaDrvLow (sdaDrvLow)
  );

  i2cb_datapath #(.QUARTER_CYCLES(QUARTER_CYCLES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (wrData),
    .sdaIn   (sdaIn),
    .qTick   (qTick),
    .txBit   (txBit),
    .rxBit   (rxBit),
    .dataReg (dataOut)
  );

endmodule

// File: rtl/i2c_byte_master_chk.sv
module i2c_byte_master_chk (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] ctlOut,
  input logic [7:0] statusOut,
  input logic       irq,
  input logic       sclDrvLow,
  input logic       sdaDrvLow
);

  AST_FLAG_HOLDS_SCL: assert property (@(posedge clk) disable iff (!rstN)
    (irq && statusOut != 8'h00) |-> sclDrvLow); // R8

  AST_IDLE_LINES_FREE: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut == 8'hF8 && ctlOut[5:4] == 2'b00) |-> (!sclDrvLow && !sdaDrvLow)); // R9

  AST_STOP_KEEPS_FLAG_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctlOut[4]) |-> !irq); // R9

  AST_FLAG_RISE_NOT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> (statusOut != 8'hF8)); // R3

  AST_ERROR_NO_SCL: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut == 8'h00 && !ctlOut[5]) |-> !sclDrvLow); // R10

  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut == 8'h00 || statusOut == 8'h08 || statusOut == 8'h10 ||
     statusOut == 8'h18 || statusOut == 8'h20 || statusOut == 8'h28 ||
     statusOut == 8'h30 || statusOut == 8'h40 || statusOut == 8'h48 ||
     statusOut == 8'h50 || statusOut == 8'h58 || statusOut == 8'hF8)); // R5

endmodule

bind i2c_byte_master i2c_byte_master_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .ctlOut    (ctlOut),
  .statusOut (statusOut),
  .irq       (irq),
  .sclDrvLow (sclDrvLow),
  .sdaDrvLow (sdaDrvLow)
);

// File: tb/i2c_byte_master_tb.sv
`timescale 1ns/1ps
module i2c_byte_master_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctlWrEn = 1'b0, dataWrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] ctlOut, dataOut, statusOut;
  logic irq, sclDrvLow, sdaDrvLow;
  logic sclLine, sdaLine;

  logic slvSdaLow = 1'b0;
  logic slvActive = 1'b0;
  logic [8:0] slvPat = '0;
  int slvCnt = 0;
  logic [8:0] wireBits = '0;
  int startSeen = 0, stopSeen = 0;
  int nChk = 0, nBad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  assign sclLine = ~sclDrvLow;
  assign sdaLine = ~(sdaDrvLow | slvSdaLow);

  i2c_byte_master #(.QUARTER_CYCLES(4)) dut_i (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .dataWrEn(dataWrEn),
    .wrData(wrData), .ctlOut(ctlOut), .dataOut(dataOut),
    .statusOut(statusOut), .irq(irq), .sclDrvLow(sclDrvLow),
    .sdaDrvLow(sdaDrvLow), .sdaIn(sdaLine)
  );

  // device model: presents one pattern bit per SCL low period
  always @(negedge sclLine) begin
    if (slvActive) begin
      slvCnt = slvCnt + 1;
      if (slvCnt >= 9) begin
        slvActive = 1'b0;
        slvSdaLow = 1'b0;
      end else begin
        slvSdaLow = slvPat[8 - slvCnt];
      end
    end
  end

  always @(posedge sclLine) wireBits = {wireBits[7:0], sdaLine};
  always @(negedge sdaLine) if (sclLine === 1'b1) startSeen++;
  always @(posedge sdaLine) if (sclLine === 1'b1) stopSeen++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic arm(input logic [8:0] p);
    slvPat = p;
    slvCnt = 0;
    slvSdaLow = p[8];
    slvActive = 1'b1;
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk); ctlWrEn = 1'b1; wrData = v;
    @(negedge clk); ctlWrEn = 1'b0;
  endtask

  task automatic wr_data(input logic [7:0] v);
    @(negedge clk); dataWrEn = 1'b1; wrData = v;
    @(negedge clk); dataWrEn = 1'b0;
  endtask

  task automatic wait_flag(input string req);
    int n = 0;
    while (irq !== 1'b1 && n < 1000) begin @(negedge clk); n++; end
    chk({req, " flag"}, irq, 1'b1);
  endtask

  task automatic wait_stop();
    int n = 0;
    while (ctlOut[4] !== 1'b0 && n < 1000) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  // pattern for device acknowledging a master-sent byte
  function automatic logic [8:0] ackPat(input bit ack);
    return {8'h00, ack};
  endfunction

  task automatic send_byte(input logic [7:0] b, input bit ack, input logic [7:0] expSt, input string req);
    wr_data(b);
    arm(ackPat(ack));
    wr_ctl(8'h40);
    wait_flag(req);
    chk({req, " status"}, statusOut, expSt);
    chk({req, " wire byte"}, wireBits[8:1], b);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 status", statusOut, 8'hF8);
    chk("R1 ctl", ctlOut, 8'h00);
    chk("R1 flag", irq, 1'b0);
    chk("R1 lines", {sclLine, sdaLine}, 2'b11);
  endtask

  task automatic t_start_idle();
    int s0 = startSeen;
    wr_ctl(8'h60);
    chk("R2 start pending readback", ctlOut, 8'h60);
    wait_flag("R3");
    chk("R3 status", statusOut, 8'h08);
    chk("R3 start seen", startSeen - s0, 1);
    chk("R2 readback after start", ctlOut, 8'h48);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sclLine !== 1'b0) begin chk("R8 scl held low", sclLine, 1'b0); break; end
    end
    chk("R8 flag still set", irq, 1'b1);
  endtask

  task automatic t_write_path();
    send_byte(8'hA0, 1'b1, 8'h18, "R5 addr write ack");
    chk("R5 ack slot released", wireBits[0], 1'b0);
    send_byte(8'h3C, 1'b1, 8'h28, "R6 data ack");
    send_byte(8'h81, 1'b0, 8'h30, "R6 data nack");
  endtask

  task automatic t_read_path();
    int s0 = startSeen;
    wr_ctl(8'h60);
    wait_flag("R4");
    chk("R4 status", statusOut, 8'h10);
    chk("R4 repeated start seen", startSeen - s0, 1);
    send_byte(8'hA1, 1'b1, 8'h40, "R5 addr read ack");
    arm({~8'h5A, 1'b0});
    wr_ctl(8'h44);
    chk("R2 aak readback", ctlOut, 8'h44);
    wait_flag("R7");
    chk("R7 status ack", statusOut, 8'h50);
    chk("R7 data ack", dataOut, 8'h5A);
    chk("R7 master ack low", wireBits[0], 1'b0);
    arm({~8'hC3, 1'b0});
    wr_ctl(8'h40);
    wait_flag("R7");
    chk("R7 status nack", statusOut, 8'h58);
    chk("R7 data nack", dataOut, 8'hC3);
    chk("R7 master nack high", wireBits[0], 1'b1);
  endtask

  task automatic t_stop();
    int p0 = stopSeen;
    wr_ctl(8'h50);
    chk("R2 stop pending", ctlOut[4], 1'b1);
    wait_stop();
    chk("R9 status", statusOut, 8'hF8);
    chk("R9 flag clear", irq, 1'b0);
    chk("R9 stop seen", stopSeen - p0, 1);
    chk("R9 lines free", {sclLine, sdaLine}, 2'b11);
  endtask

  task automatic t_addr_nack();
    wr_ctl(8'h60);
    wait_flag("R3");
    send_byte(8'hA0, 1'b0, 8'h20, "R5 addr write nack");
    wr_ctl(8'h60);
    wait_flag("R4");
    send_byte(8'hA1, 1'b0, 8'h48, "R5 addr read nack");
    t_stop();
  endtask

  task automatic t_error();
    bit sclMoved = 0;
    wr_ctl(8'h40);
    @(negedge clk);
    chk("R10 status", statusOut, 8'h00);
    chk("R10 flag", irq, 1'b1);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (sclLine !== 1'b1) sclMoved = 1;
    end
    chk("R10 scl idle", sclMoved, 1'b0);
  endtask

  task automatic t_ignored();
    int s0 = startSeen;
    wr_ctl(8'h20);
    repeat (30) @(negedge clk);
    chk("R11 no-enable flag", irq, 1'b1);
    chk("R11 no-enable status", statusOut, 8'h00);
    chk("R11 no-enable start", startSeen - s0, 0);
    chk("R11 no-enable pending", ctlOut[5], 1'b0);
    wr_ctl(8'h60);
    wait_flag("R3");
    chk("R3 start after error", statusOut, 8'h08);
    wr_data(8'hA0);
    arm(ackPat(1'b1));
    wr_ctl(8'h40);
    repeat (20) @(negedge clk);
    wr_data(8'h11);
    wr_ctl(8'h50);
    wait_flag("R11");
    chk("R11 busy status", statusOut, 8'h18);
    chk("R11 busy data kept", dataOut, 8'hA0);
    chk("R11 busy stop dropped", ctlOut[4], 1'b0);
    t_stop();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_start_idle();
    t_write_path();
    t_read_path();
    t_stop();
    t_addr_nack();
    t_error();
    t_ignored();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChk++; nBad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

endmodule